// File: doc/BRIEF.md
# Unaligned Block Write Splitter

This block accepts a byte-granular write: a start byte address, a length in bytes, and the payload as a stream of bytes in address order. It turns the write into a series of naturally aligned 8, 16 or 32-bit writes on a 32-bit bus with byte strobes. At each step it picks the widest access that suits both the current address alignment and the number of bytes still to go. For example, 10 bytes starting at 0x5 become a byte at 0x5, a halfword at 0x6, a word at 0x8, a halfword at 0xC and a byte at 0xE.

The request is taken with a valid/ready handshake while the block is idle. Payload bytes are pulled one per accepted beat until the current piece is complete. The piece is then held on the bus until the bus accepts it. A one-cycle done pulse follows the final piece. During that same cycle the block is already idle and can take the next request.

Top module: `uwsplit_top`

## Requirements
- R1: After reset, reqReady is 1 and inReady, busValid and done are 0.
- R2: A 32-bit piece (busSize = 2) is issued when the current address has both low bits zero and at least 4 bytes remain.
- R3: Otherwise, a 16-bit piece (busSize = 1) is issued when the address bit 0 is zero and at least 2 bytes remain.
- R4: In every other case, an 8-bit piece (busSize = 0) is issued.
- R5: busStrb bit i is set exactly for lanes busAddr[1:0] through busAddr[1:0]+size-1. Lane i is busData[8i+7:8i] (little-endian).
- R6: Payload bytes go to lanes in address order: the byte for address A lands in lane A[1:0]. Lanes without a strobe read zero.
- R7: While busValid is high and busReady is low, busValid, busAddr, busSize, busStrb and busData hold steady. The address and the remaining count advance only on a completed bus handshake.
- R8: Pieces are issued in strictly increasing address order, one per handshake, and together they cover the request exactly. A 10-byte request at 0x5 gives (0x5,8b),(0x6,16b),(0x8,32b),(0xC,16b),(0xE,8b).
- R9: A zero-length request gives a done pulse in the next cycle. It issues no bus write and raises no inReady.
- R10: done is high for the single cycle after the final handshake. reqReady is high in that same cycle, and a request presented then is accepted.
- R11: inReady is high only while the current piece still lacks bytes, so exactly size bytes are taken per piece. inReady and busValid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted when reqValid is high |
| reqAddr | input | ADDR_W | Start byte address |
| reqLen | input | LEN_W | Length in bytes |
| inValid | input | 1 | Payload byte present |
| inReady | output | 1 | Payload byte taken when inValid is high |
| inByte | input | 8 | Payload byte |
| busValid | output | 1 | Bus write present |
| busReady | input | 1 | Bus accepts the write |
| busAddr | output | ADDR_W | Byte address of the piece |
| busSize | output | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| busStrb | output | 4 | Byte lane enables |
| busData | output | 32 | Write data, lane i in bits 8i+7:8i |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The completion of one request and the acceptance of the next can fall in the same cycle. done pulses while reqReady is high, and a waiting reqValid is taken on that edge. The bench provokes this by presenting the next request right after each acceptance, including zero-length requests that finish straight away. A behavioural per-cycle model predicts reqReady, inReady, busValid and done on every clock, so a missed or doubled done, or a dropped back-to-back request, shows up as a mismatch. Random stalls on the payload stream and on busReady check that the splitting and the lane placement do not depend on when the handshakes happen.

// File: rtl/uwsplit_pkg.sv
package uwsplit_pkg;
  typedef struct packed {
    logic loadReq;
    logic takeByte;
    logic advance;
  } ctlStrobe_t;

  typedef struct packed {
    logic pieceFull;
    logic lastPiece;
    logic reqEmpty;
  } dpStatus_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/uwsplit_datapath.sv
module uwsplit_datapath
  import uwsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        inByte,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [3:0]        busStrb,
  output logic [31:0]       busData
);
  localparam int LANES = 4;

  logic [ADDR_W-1:0]     curAddr;
  logic [LEN_W-1:0]      remLen;
  logic [LANES-1:0][7:0] lanes;
  logic [2:0]            fillCnt;
  logic [1:0]            sizeCode;
  logic [2:0]            sizeBytes;
  logic [2:0]            laneLo;
  logic [1:0]            wrLane;

  always_comb begin
    if (curAddr[1:0] == 2'b00 && remLen > LEN_W'(3))      sizeCode = SZ_WORD;
    else if (!curAddr[0] && remLen > LEN_W'(1))           sizeCode = SZ_HALF;
    else                                                  sizeCode = SZ_BYTE;
  end

  assign sizeBytes        = 3'd1 << sizeCode;
  assign laneLo           = {1'b0, curAddr[1:0]};
  assign wrLane           = curAddr[1:0] + fillCnt[1:0];
  assign status.pieceFull = (fillCnt == sizeBytes);
  assign status.lastPiece = (remLen == LEN_W'(sizeBytes));
  assign status.reqEmpty  = (reqLen == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      lanes   <= '0;
      fillCnt <= '0;
    end else if (ctl.loadReq) begin
      curAddr <= reqAddr;
      remLen  <= reqLen;
      lanes   <= '0;
      fillCnt <= '0;
    end else if (ctl.advance) begin
      curAddr <= curAddr + ADDR_W'(sizeBytes);
      remLen  <= remLen - LEN_W'(sizeBytes);
      lanes   <= '0;
      fillCnt <= '0;
    end else if (ctl.takeByte) begin
      lanes[wrLane] <= inByte;
      fillCnt       <= fillCnt + 3'd1;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_strb
    assign busStrb[i] = (3'(i) >= laneLo) && (3'(i) < laneLo + sizeBytes);
  end

  assign busAddr = curAddr;
  assign busSize = sizeCode;
  assign busData = lanes;

  // R7
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.loadReq) |=> ($stable(curAddr) && $stable(remLen)));

  // R11
  fill_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= 3'd4);
endmodule

// File: rtl/uwsplit_control.sv
module uwsplit_control
  import uwsplit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       inValid,
  input  logic       busReady,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       reqReady,
  output logic       inReady,
  output logic       busValid,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;

  state_t stateQ, stateD;
  logic   finishing;

  always_comb begin
    reqReady     = (stateQ == ST_IDLE);
    inReady      = (stateQ == ST_BUSY) && !status.pieceFull;
    busValid     = (stateQ == ST_BUSY) && status.pieceFull;
    ctl.loadReq  = reqReady && reqValid;
    ctl.takeByte = inReady && inValid;
    ctl.advance  = busValid && busReady;
    finishing    = (ctl.loadReq && status.reqEmpty) ||
                   (ctl.advance && status.lastPiece);
    stateD       = stateQ;
    if (ctl.loadReq && !status.reqEmpty)         stateD = ST_BUSY;
    else if (ctl.advance && status.lastPiece)    stateD = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= finishing;
    end
  end

  // R9
  empty_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && status.reqEmpty) |=> (done && reqReady));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R7
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busValid);
endmodule

// File: rtl/uwsplit_top.sv
module uwsplit_top
  import uwsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inByte,
  output logic              busValid,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [3:0]        busStrb,
  output logic [31:0]       busData,
  output logic              done
);
  ctlStrobe_t ctl;
  dpStatus_t  status;

  uwsplit_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .inValid(inValid),
    .busReady(busReady), .status(status), .ctl(ctl), .reqReady(reqReady),
    .inReady(inReady), .busValid(busValid), .done(done)
  );

  uwsplit_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqLen(reqLen),
    .inByte(inByte), .status(status), .busAddr(busAddr), .busSize(busSize),
    .busStrb(busStrb), .busData(busData)
  );

  // R7
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> ($stable(busAddr) && $stable(busData) &&
                                 $stable(busStrb) && $stable(busSize)));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busSize == SZ_WORD) |-> (busAddr[1:0] == 2'b00));

  // R3
  half_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busSize == SZ_HALF) |-> !busAddr[0]);

  // R5
  strb_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($countones(busStrb) == (32'd1 << busSize)));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && busValid));
endmodule

// File: tb/uwsplit_top_tb.sv
module uwsplit_top_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int NREQ   = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic              inValid = 1'b0, inReady;
  logic [7:0]        inByte = '0;
  logic              busValid, busReady = 1'b0;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0]        busSize;
  logic [3:0]        busStrb;
  logic [31:0]       busData;
  logic              done;

  always #2 clk = ~clk;

  uwsplit_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .inValid(inValid), .inReady(inReady),
    .inByte(inByte), .busValid(busValid), .busReady(busReady),
    .busAddr(busAddr), .busSize(busSize), .busStrb(busStrb),
    .busData(busData), .done(done)
  );

  int nChk = 0, nBad = 0;
  int reqA [NREQ];
  int reqL [NREQ];

  // behavioural model state
  bit mBusy = 0, mDone = 0;
  int mAddr = 0, mRem = 0, mFill = 0, mBase = 0, mReqIdx = 0;
  int acceptCount = 0, seenAccept = 0;
  int logA [8];
  int logS [8];
  int logN = 0;

  function automatic int pickSize(int a, int r);
    if (a % 4 == 0 && r >= 4) return 4;
    if (a % 2 == 0 && r >= 2) return 2;
    return 1;
  endfunction

  function automatic logic [7:0] genByte(int r, int k);
    return 8'((r * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: advances on the edge from the inputs the bench drove
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mFill = 0;
    end else if (!mBusy) begin
      mDone = 0;
      if (reqValid) begin
        mReqIdx = acceptCount;
        acceptCount++;
        if (reqLen == 0) mDone = 1;
        else begin
          mBusy = 1; mAddr = int'(reqAddr); mRem = int'(reqLen);
          mFill = 0; mBase = 0;
        end
      end
    end else begin
      int sz;
      sz = pickSize(mAddr, mRem);
      mDone = 0;
      if (mFill < sz) begin
        if (inValid) mFill++;
      end else if (busReady) begin
        if (mReqIdx == 0 && logN < 8) begin
          logA[logN] = mAddr; logS[logN] = sz; logN++;
        end
        mAddr += sz; mRem -= sz; mBase += sz; mFill = 0;
        if (mRem == 0) begin mBusy = 0; mDone = 1; end
      end
    end
  end

  // compare on every clock away from the edge, then drive the next inputs
  always @(negedge clk) begin
    if (rstN) begin
      int sz;
      bit eBusV;
      sz = mBusy ? pickSize(mAddr, mRem) : 1;
      eBusV = mBusy && (mFill == sz);
      check(reqReady == !mBusy, "R10", "reqReady", reqReady, !mBusy);
      check(inReady == (mBusy && mFill < sz), "R11", "inReady", inReady, mBusy && mFill < sz);
      check(busValid == eBusV, "R7", "busValid", busValid, eBusV);
      check(done == mDone, "R10", "done", done, mDone);
      if (eBusV && busValid) begin
        logic [3:0]  eStrb;
        logic [31:0] eData;
        int lo;
        lo = mAddr % 4; eStrb = '0; eData = '0;
        for (int k = 0; k < sz; k++) begin
          eStrb[lo + k] = 1'b1;
          eData[8*(lo+k) +: 8] = genByte(mReqIdx, mBase + k);
        end
        check(busAddr == ADDR_W'(mAddr), "R8", "busAddr", busAddr, mAddr);
        if (sz == 4)      check(busSize == 2'd2, "R2", "busSize", busSize, 2);
        else if (sz == 2) check(busSize == 2'd1, "R3", "busSize", busSize, 1);
        else              check(busSize == 2'd0, "R4", "busSize", busSize, 0);
        check(busStrb == eStrb, "R5", "busStrb", busStrb, eStrb);
        check(busData == eData, "R6", "busData", busData, eData);
      end
    end
    // drive
    if (acceptCount != seenAccept) begin
      seenAccept = acceptCount;
      reqValid = 1'b0;
    end
    if (rstN && !reqValid && acceptCount < NREQ && ($urandom % 2 == 0 || acceptCount < 2)) begin
      reqValid = 1'b1;
      reqAddr  = ADDR_W'(reqA[acceptCount]);
      reqLen   = LEN_W'(reqL[acceptCount]);
    end
    inValid  = ($urandom % 4) != 0;
    busReady = ($urandom % 3) != 0;
    inByte   = mBusy ? genByte(mReqIdx, mBase + mFill) : 8'h00;
  end

  initial begin
    int cyc;
    int expA [5] = '{5, 6, 8, 12, 14};
    int expS [5] = '{1, 2, 4, 2, 1};
    reqA[0] = 5;  reqL[0] = 10;   // R8 directed sequence
    reqA[1] = 0;  reqL[1] = 0;    // R9 zero length
    reqA[2] = 3;  reqL[2] = 1;
    reqA[3] = 2;  reqL[3] = 2;
    reqA[4] = 0;  reqL[4] = 8;
    reqA[5] = 1;  reqL[5] = 7;
    reqA[6] = 6;  reqL[6] = 0;
    reqA[7] = 7;  reqL[7] = 3;
    for (int i = 8; i < NREQ; i++) begin
      reqA[i] = int'($urandom % 64);
      reqL[i] = int'($urandom % 24);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check(inReady == 1'b0, "R1", "inReady", inReady, 0);
    check(busValid == 1'b0, "R1", "busValid", busValid, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    cyc = 0;
    while (!(acceptCount == NREQ && !mBusy) && cyc < 50000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 50000) check(1'b0, "R10", "watchdog", cyc, 0);
    repeat (3) @(negedge clk);
    // R8 sequence for 10 bytes at 0x5
    check(logN == 5, "R8", "piece count", logN, 5);
    for (int i = 0; i < 5; i++) begin
      check(logA[i] == expA[i], "R8", "piece addr", logA[i], expA[i]);
      check(logS[i] == expS[i], "R8", "piece size", logS[i], expS[i]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule